// File: doc/BRIEF.md
# Two-Wire Slave Register Port

This block is a serial slave that gives an external microcontroller access to a bank of four 8-bit registers over a two-wire bus (clock plus open-drain data). The controller always drives the bus clock. The block oversamples both bus lines with a faster system clock and recognises START, repeated START and STOP conditions. It answers only to one fixed 7-bit device address. In a write, the first byte after the address is a register pointer and the bytes after it are data. In a read, data comes out from wherever the pointer was left. A transaction moves at most three data bytes.

On the chip side, the register bank can be read through a parallel port, and a host-side write port can change any register. Every byte the controller writes produces a one-cycle strobe that carries the register index. Other logic can use this strobe to start an upstream report. When the host writes the mailbox register, an interrupt flag is set. The flag clears when the controller reads that register over the bus.

Top module: `i2c_regport`

## Requirements
- R1: Only the address byte 0x38 with R/W in bit 0 (1 = read) is acknowledged. Any other address is NACKed (data line released during the 9th clock), and the rest of that transaction has no effect on the registers, the strobe or the data line.
- R2: In a write transaction, the first byte after the address is acknowledged, and its two least significant bits load the register pointer.
- R3: Each later write byte is acknowledged and stored into the pointed register. The pointer then increments modulo 4, and `wr_strobe` pulses for one cycle with `wr_idx` equal to the written register's index.
- R4: At most 3 data bytes are accepted per transaction. A 4th write byte is NACKed, is not stored and produces no strobe.
- R5: A read transaction returns, MSB first, the register at the current pointer. The pointer increments modulo 4 after each byte, and its value carries over from earlier transactions.
- R6: The slave releases the data line when the controller NACKs a read byte. It also releases it after the 3rd byte of a transaction, so any further read byte arrives as 0xFF.
- R7: A repeated START begins a new address phase and resets the per-transaction byte count and the pointer-byte expectation.
- R8: A host write (`host_we`) updates the addressed register so that `host_rdata` shows it on the next cycle. If a bus write and a host write hit the same register in the same cycle, the host write wins.
- R9: A host write to register 3 sets `dn_irq`. A bus read that fetches register 3 clears it. Host writes and bus reads of the other registers leave it unchanged.
- R10: The data line is pulled low only starting in a clock-low phase and stays constant while the bus clock is high, except for the controller's own START and STOP.
- R11: After reset all registers and the pointer are 0, `dn_irq` is 0 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock input |
| sda_i | input | 1 | Bus data input (resolved line level) |
| sda_oe | output | 1 | 1 pulls the bus data line low, 0 releases it |
| host_we | input | 1 | Host-side register write enable |
| host_waddr | input | 2 | Host-side write register index |
| host_wdata | input | 8 | Host-side write data |
| host_raddr | input | 2 | Parallel read register index |
| host_rdata | output | 8 | Parallel read data |
| wr_strobe | output | 1 | One-cycle pulse per accepted bus write byte |
| wr_idx | output | 2 | Register index written by the bus, valid with `wr_strobe` |
| dn_irq | output | 1 | Mailbox flag: host deposited a byte in register 3 |

## Verification
The hardest case to reach is the end of a burst. A controller has to keep acknowledging past the third read byte, or keep writing past the third data byte, before the slave's refusal shows up at all. A repeated START must also arrive before the byte counter has been cleared by a STOP. The bench sweeps every start pointer against every burst length for both directions and pushes one byte beyond the limit in each direction. It then chains pointer-set, three writes and a read through repeated STARTs in a single transaction, so the count has to reset mid-transaction.

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter logic [6:0] DEV_ADDR  = 7'h38,
  parameter int         MAX_BURST = 3,
  parameter logic [1:0] IRQ_REG   = 2'd3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       host_we,
  input  logic [1:0] host_waddr,
  input  logic [7:0] host_wdata,
  input  logic [1:0] host_raddr,
  output logic [7:0] host_rdata,
  output logic       wr_strobe,
  output logic [1:0] wr_idx,
  output logic       dn_irq
);
  localparam int BW = $clog2(MAX_BURST + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACK, S_RX, S_TX, S_MACK} st_t;

  logic [2:0]    scl_s, sda_s;
  st_t           st;
  logic [3:0]    cnt;
  logic [7:0]    sh, tx;
  logic [1:0]    ptr;
  logic [BW-1:0] nb;
  logic          rw, have_ptr, ack_ok;
  logic [7:0]    regs [4];

  wire scl_r = scl_s[1];
  wire scl_d = scl_s[2];
  wire sda_r = sda_s[1];
  wire sda_d = sda_s[2];

  wire start    = scl_r & scl_d & sda_d & ~sda_r;
  wire stop     = scl_r & scl_d & ~sda_d & sda_r;
  wire scl_rise = scl_r & ~scl_d;
  wire scl_fall = ~scl_r & scl_d;
  wire room     = int'(nb) < MAX_BURST;

  wire do_load = scl_fall && !start && !stop &&
                 ((st == S_ACK && rw) || (st == S_MACK && ack_ok && room));

  wire [7:0] cur = regs[ptr];

  assign host_rdata = regs[host_raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 3'b111;
      sda_s <= 3'b111;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      ptr       <= '0;
      nb        <= '0;
      rw        <= 1'b0;
      have_ptr  <= 1'b0;
      ack_ok    <= 1'b0;
      sda_oe    <= 1'b0;
      wr_strobe <= 1'b0;
      wr_idx    <= '0;
      dn_irq    <= 1'b0;
      for (int i = 0; i < 4; i++) regs[i] <= '0;
    end else begin
      wr_strobe <= 1'b0;
      if (start) begin
        st       <= S_ADDR;
        cnt      <= '0;
        nb       <= '0;
        have_ptr <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        case (st)
          S_ADDR, S_RX: begin
            sh  <= {sh[6:0], sda_r};
            cnt <= cnt + 4'd1;
          end
          S_MACK:  ack_ok <= ~sda_r;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (st)
          S_ADDR:
            if (cnt == 4'd8) begin
              if (sh[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                rw     <= sh[0];
                st     <= S_ACK;
              end else begin
                st <= S_IDLE;
              end
            end
          S_ACK: begin
            cnt <= '0;
            if (!rw) begin
              sda_oe <= 1'b0;
              st     <= S_RX;
            end
          end
          S_RX:
            if (cnt == 4'd8) begin
              cnt <= '0;
              if (!have_ptr) begin
                ptr      <= sh[1:0];
                have_ptr <= 1'b1;
                sda_oe   <= 1'b1;
                st       <= S_ACK;
              end else if (room) begin
                regs[ptr] <= sh;
                wr_strobe <= 1'b1;
                wr_idx    <= ptr;
                ptr       <= ptr + 2'd1;
                nb        <= nb + 1'b1;
                sda_oe    <= 1'b1;
                st        <= S_ACK;
              end else begin
                st <= S_IDLE;
              end
            end
          S_TX:
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              st     <= S_MACK;
            end else begin
              sda_oe <= ~tx[7];
              tx     <= {tx[6:0], 1'b0};
              cnt    <= cnt + 4'd1;
            end
          S_MACK:
            if (!do_load) st <= S_IDLE;
          default: ;
        endcase
      end

      if (do_load) begin
        sda_oe <= ~cur[7];
        tx     <= {cur[6:0], 1'b0};
        cnt    <= 4'd1;
        ptr    <= ptr + 2'd1;
        nb     <= nb + 1'b1;
        st     <= S_TX;
        if (ptr == IRQ_REG) dn_irq <= 1'b0;
      end

      if (host_we) begin
        regs[host_waddr] <= host_wdata;
        if (host_waddr == IRQ_REG) dn_irq <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk #(
  parameter logic [1:0] IRQ_REG = 2'd3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       host_we,
  input logic [1:0] host_waddr,
  input logic [7:0] host_wdata,
  input logic [1:0] host_raddr,
  input logic [7:0] host_rdata,
  input logic       wr_strobe,
  input logic       dn_irq
);
  a_r10_pull_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  a_r3_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);

  a_r3_strobe_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> !scl_i);

  a_r8_host_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_raddr == host_waddr) |=>
      (!$stable(host_raddr) || host_rdata == $past(host_wdata)));

  a_r9_irq_rises_on_host: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_irq) |-> $past(host_we && host_waddr == IRQ_REG));

  a_r9_irq_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_waddr == IRQ_REG) |=> dn_irq);
endmodule

bind i2c_regport i2c_regport_chk #(.IRQ_REG(IRQ_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
  .host_raddr(host_raddr), .host_rdata(host_rdata),
  .wr_strobe(wr_strobe), .dn_irq(dn_irq)
);

// File: tb/tb_i2c_regport.sv
module tb_i2c_regport;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, wr_strobe, dn_irq;
  logic host_we = 1'b0;
  logic [1:0] host_waddr = '0, host_raddr = '0, wr_idx;
  logic [7:0] host_wdata = '0, host_rdata;
  wire sda_line = m_sda & ~sda_oe;

  int vectors = 0, fails = 0, nstrobe = 0, glitches = 0;
  logic [1:0] last_idx = '0;
  logic [7:0] m [4];
  logic [1:0] mptr;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_regport dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata),
    .wr_strobe(wr_strobe), .wr_idx(wr_idx), .dn_irq(dn_irq)
  );

  always @(posedge clk) if (wr_strobe) begin nstrobe++; last_idx <= wr_idx; end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic b_start;
    m_sda = 1; wq(Q); m_scl = 1; wq(2*Q); m_sda = 0; wq(2*Q); m_scl = 0;
  endtask
  task automatic b_stop;
    wq(Q); m_sda = 0; wq(Q); m_scl = 1; wq(2*Q); m_sda = 1; wq(2*Q);
  endtask
  task automatic bit_w(input logic b);
    wq(Q); m_sda = b; wq(Q); m_scl = 1; wq(2*Q); m_scl = 0;
  endtask
  task automatic bit_r(output logic b);
    logic b2;
    wq(Q); m_sda = 1; wq(Q); m_scl = 1; wq(Q); b = sda_line; wq(Q - 1);
    b2 = sda_line; if (b2 != b) glitches++; wq(1); m_scl = 0;
  endtask
  task automatic wr_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(b); ack = !b;
  endtask
  task automatic rd_byte(input bit ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_r(d[i]);
    bit_w(!ack);
  endtask
  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1; host_waddr = a; host_wdata = d;
    @(negedge clk); host_we = 0; m[a] = d;
  endtask
  task automatic check_regs(input string req);
    for (int i = 0; i < 4; i++) begin
      host_raddr = 2'(i); wq(1); chk(req, host_rdata, m[i]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    int s0;
    for (int i = 0; i < 4; i++) m[i] = 8'h00;
    mptr = 0;
    wq(5); rst_n = 1; wq(5);

    // R11 reset state
    chk("R11 sda_oe", sda_oe, 0);
    chk("R11 dn_irq", dn_irq, 0);
    check_regs("R11 reg");

    // R2 R3 write sweep: every start pointer, every burst length
    for (int p = 0; p < 4; p++)
      for (int n = 1; n <= 3; n++) begin
        s0 = nstrobe;
        b_start;
        wr_byte(8'h70, ack); chk("R1 addr ack", ack, 1);
        wr_byte(8'hA4 | 8'(p), ack); chk("R2 ptr ack", ack, 1);
        for (int k = 0; k < n; k++) begin
          d = 8'(p * 37 + n * 11 + k * 5 + 1);
          wr_byte(d, ack); chk("R3 data ack", ack, 1);
          m[(p + k) % 4] = d;
          chk("R3 wr_idx", last_idx, (p + k) % 4);
        end
        b_stop;
        chk("R3 strobe count", nstrobe - s0, n);
        mptr = 2'((p + n) % 4);
        check_regs("R3 reg");
      end

    // R4 fourth write byte refused
    s0 = nstrobe;
    b_start;
    wr_byte(8'h70, ack); wr_byte(8'h01, ack);
    for (int k = 0; k < 3; k++) begin
      wr_byte(8'hC0 + 8'(k), ack); chk("R4 in-limit ack", ack, 1);
      m[(1 + k) % 4] = 8'hC0 + 8'(k);
    end
    wr_byte(8'h5A, ack); chk("R4 4th nack", ack, 0);
    b_stop;
    chk("R4 strobe count", nstrobe - s0, 3);
    check_regs("R4 reg");
    mptr = 0;

    // R1 every foreign address refused
    s0 = nstrobe;
    for (int a = 0; a < 128; a++) begin
      if (a == 'h38) continue;
      b_start;
      wr_byte({7'(a), 1'(a)}, ack);
      chk("R1 foreign nack", ack, 0);
      b_stop;
    end
    chk("R1 no strobe", nstrobe - s0, 0);
    check_regs("R1 reg");

    // R8 host writes
    host_wr(0, 8'h3C); host_wr(1, 8'h81); host_wr(2, 8'hE7); host_wr(3, 8'h5D);
    check_regs("R8 host reg");

    // R5 R6 read sweep
    for (int p = 0; p < 4; p++)
      for (int n = 1; n <= 3; n++) begin
        b_start; wr_byte(8'h70, ack); wr_byte(8'(p), ack); b_stop;
        b_start;
        wr_byte(8'h71, ack); chk("R1 read addr ack", ack, 1);
        for (int k = 0; k < n; k++) begin
          rd_byte(n == 3 || k != n - 1, d);
          chk("R5 read data", d, m[(p + k) % 4]);
        end
        if (n == 3) begin
          rd_byte(0, d); chk("R6 past-limit byte", d, 8'hFF);
        end
        b_stop;
        b_start; wr_byte(8'h71, ack); rd_byte(0, d); b_stop;
        chk("R5 pointer persists", d, m[(p + n) % 4]);
      end

    // R7 repeated START chain
    s0 = nstrobe;
    b_start;
    wr_byte(8'h70, ack); wr_byte(8'h02, ack); wr_byte(8'h11, ack); m[2] = 8'h11;
    b_start;
    wr_byte(8'h70, ack); chk("R7 addr after Sr", ack, 1);
    wr_byte(8'h00, ack); chk("R7 ptr after Sr", ack, 1);
    for (int k = 0; k < 3; k++) begin
      wr_byte(8'h20 + 8'(k), ack); chk("R7 count reset ack", ack, 1);
      m[k] = 8'h20 + 8'(k);
    end
    b_start;
    wr_byte(8'h71, ack); rd_byte(0, d); chk("R7 read after Sr", d, m[3]);
    b_stop;
    chk("R7 strobe count", nstrobe - s0, 4);
    check_regs("R7 reg");

    // R9 mailbox flag
    host_wr(1, 8'h99);
    chk("R9 other reg no irq", dn_irq, 0);
    host_wr(3, 8'h42);
    chk("R9 irq set", dn_irq, 1);
    b_start; wr_byte(8'h70, ack); wr_byte(8'h02, ack); b_stop;
    b_start; wr_byte(8'h71, ack); rd_byte(0, d); b_stop;
    chk("R9 read reg2 keeps irq", dn_irq, 1);
    b_start; wr_byte(8'h71, ack); rd_byte(0, d); b_stop;
    chk("R9 read value", d, 8'h42);
    chk("R9 irq cleared", dn_irq, 0);

    // R10 line stable while clock high
    chk("R10 no high-phase change", glitches, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule